// File: doc/BRIEF.md
# Slow-Clock Reset Sequencer with Strap Capture

This block produces the system-wide reset from two sources: an active-low reset pin on the board and a reset request from the on-chip watchdog. It runs on the 32.768 kHz slow clock. The internal reset goes active at once when the pin drops, with no clock edge needed. It comes out of reset in step with the slow clock. A watchdog request holds the internal reset for a fixed stretch of slow-clock cycles.

While the pin is held low, the block keeps a rolling record of two configuration straps: a boot-mode select and an active-low request for tri-state mode. When the pin is released after a long enough low period, the record decides the latched boot mode and whether all output drivers stay disabled from then on. The core logic keeps running in tri-state mode. A watchdog reset never touches the latched modes.

While reset is active the block also forces peripheral clock enables off and drives the external address bus to zero. The clock-out pin carries the slow clock during reset, and afterwards until software switches that pin to general-purpose use.

Top module: `rst_seq_ctrl`

## Requirements
- R1: `sys_rst_n` is 0 whenever `ext_rst_n` is 0, including between clock edges right after the pin falls.
- R2: When no watchdog stretch is running, `sys_rst_n` returns to 1 just after the second rising edge of `clk_slow` that finds `ext_rst_n` high.
- R3: On release, straps are latched only if the pin was seen low on at least 10 consecutive rising edges. A shorter low pulse still resets the system, but `boot_sel` and `tsm_active` keep their previous values.
- R4: After a valid release, `boot_sel` equals the `strap_boot` value sampled on the last rising edge at which the pin was low.
- R5: After a valid release, `tsm_active` is 1 only if `strap_tri_n` was 0 on each of the last 10 rising edges with the pin low. Otherwise it is 0.
- R6: `oe_out` is all zeros while `tsm_active` is 1, and equals `oe_in` otherwise.
- R7: A `wdog_req` of 1 at a rising edge with the pin high drives `sys_rst_n` to 0 after that edge. It stays 0 through the next 9 edges and returns to 1 after the 10th edge that follows.
- R8: A watchdog reset does not change `boot_sel` or `tsm_active`, and strap values presented during it have no effect.
- R9: `wdog_req` at edges where the pin is low is ignored, so the release timing of R2 holds.
- R10: While `sys_rst_n` is 0, `periph_clk_en` and `addr_out` are all zeros. Otherwise they equal `periph_clk_req` and `addr_in`.
- R11: `clk_out` follows `clk_slow` while `sys_rst_n` is 0 or `clko_gpio_en` is 0. Otherwise it follows `clko_gpio_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32.768 kHz slow clock |
| ext_rst_n | input | 1 | Board reset pin, active low |
| wdog_req | input | 1 | Watchdog reset request, sampled per edge |
| strap_boot | input | 1 | Boot-mode select strap |
| strap_tri_n | input | 1 | Tri-state request strap, active low |
| periph_clk_req | input | NPER | Peripheral clock enables from the clock controller |
| addr_in | input | ADDR_W | External address from the bus interface |
| oe_in | input | NOE | Output-enable requests of the pads |
| clko_gpio_en | input | 1 | Clock-out pin switched to general-purpose use |
| clko_gpio_val | input | 1 | General-purpose value for the clock-out pin |
| sys_rst_n | output | 1 | Internal system reset, active low |
| boot_sel | output | 1 | Latched boot mode |
| tsm_active | output | 1 | Latched tri-state mode flag |
| periph_clk_en | output | NPER | Gated peripheral clock enables |
| addr_out | output | ADDR_W | External address bus, zero in reset |
| oe_out | output | NOE | Pad output enables after tri-state gating |
| clk_out | output | 1 | Clock-out pin value |

## Verification
The assertions assume that the reset pin and `wdog_req` change away from the slow-clock rising edge. The pin is sampled directly by the strap record and is not synchronised first. They also assume that the first reset after power-up holds the pin low for the full window, so the strap record contains only known values. The bench changes every input a few nanoseconds after a rising edge. It opens every run with a 12-cycle pin reset. Random reset lengths stay between 3 and 20 cycles, which covers windows both shorter and longer than the capture window.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    // Width of the strap capture window and of the watchdog stretch, in slow-clock cycles
    parameter int DEF_WIN = 10;

    typedef struct packed {
        logic boot;
        logic tsm;
    } mode_t;
endpackage

// File: rtl/rstc_sync.sv
// Release synchroniser: cleared asynchronously, releases after STAGES rising edges
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rel_o = sync_q[STAGES-1];
endmodule

// File: rtl/rstc_strap_sampler.sv
// Keeps a rolling strap record while the pin is low and latches modes on a valid release
module rstc_strap_sampler
    import rstc_pkg::*;
#(
    parameter int WIN = DEF_WIN
) (
    input  logic  clk,
    input  logic  ext_rst_n,
    input  logic  strap_boot,
    input  logic  strap_tri_n,
    output mode_t mode_o
);
    typedef struct packed {
        logic [WIN-1:0] hist_boot;
        logic [WIN-1:0] hist_tri;
        logic [WIN-1:0] fill;
        logic           prev_low;
        mode_t          mode;
    } smp_t;

    smp_t smp_d, smp_q;
    logic pin_low;
    logic rel_edge;
    logic window_full;

    always_comb begin
        pin_low     = ~ext_rst_n;
        rel_edge    = ~pin_low & smp_q.prev_low;
        window_full = &smp_q.fill;
        smp_d       = smp_q;
        smp_d.prev_low = pin_low;
        if (pin_low) begin
            smp_d.hist_boot = {smp_q.hist_boot[WIN-2:0], strap_boot};
            smp_d.hist_tri  = {smp_q.hist_tri[WIN-2:0], strap_tri_n};
            smp_d.fill      = {smp_q.fill[WIN-2:0], 1'b1};
        end else begin
            smp_d.fill = '0;
        end
        if (rel_edge && window_full) begin
            smp_d.mode.boot = smp_q.hist_boot[0];
            smp_d.mode.tsm  = ~|smp_q.hist_tri;
        end
    end

    // No reset: this state must survive the reset it observes
    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    assign mode_o = smp_q.mode;

    AST_MODE_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (smp_q.mode != $past(smp_q.mode)) |-> $past(rel_edge)); // R8
    AST_HIST_FROZEN_WHILE_HIGH: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ext_rst_n && $past(ext_rst_n)) |-> ($stable(smp_q.hist_boot) && $stable(smp_q.hist_tri))); // R8
endmodule

// File: rtl/rstc_wdog_stretch.sv
// Stretches a watchdog request into a WIN-cycle hold of the internal reset
module rstc_wdog_stretch
    import rstc_pkg::*;
#(
    parameter int WIN = DEF_WIN
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic wdog_req,
    output logic hold_o
);
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (!ext_rst_n) begin
            wd_d.cnt = '0;            // pin reset has priority
        end else if (wdog_req) begin
            wd_d.cnt = CW'(WIN);
        end else if (wd_q.cnt != '0) begin
            wd_d.cnt = wd_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        wd_q <= wd_d;
    end

    assign hold_o = (wd_q.cnt != '0);

    AST_STRETCH_LOAD: assert property (@(posedge clk) disable iff (!ext_rst_n)
        wdog_req |=> (wd_q.cnt == CW'(WIN))); // R7
    AST_STRETCH_STEP: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (wd_q.cnt != '0 && !wdog_req) |=> (wd_q.cnt == CW'($past(wd_q.cnt) - 1'b1))); // R7
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rstc_pkg::*;
#(
    parameter int WIN    = DEF_WIN,
    parameter int SYNC_N = 2,
    parameter int NPER   = 8,
    parameter int ADDR_W = 24,
    parameter int NOE    = 16
) (
    input  logic              clk_slow,
    input  logic              ext_rst_n,
    input  logic              wdog_req,
    input  logic              strap_boot,
    input  logic              strap_tri_n,
    input  logic [NPER-1:0]   periph_clk_req,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [NOE-1:0]    oe_in,
    input  logic              clko_gpio_en,
    input  logic              clko_gpio_val,
    output logic              sys_rst_n,
    output logic              boot_sel,
    output logic              tsm_active,
    output logic [NPER-1:0]   periph_clk_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic [NOE-1:0]    oe_out,
    output logic              clk_out
);
    logic  pin_rel;
    logic  wd_hold;
    mode_t mode;

    rstc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk_slow),
        .arst_n (ext_rst_n),
        .rel_o  (pin_rel)
    );

    rstc_strap_sampler #(.WIN(WIN)) u_smp (
        .clk         (clk_slow),
        .ext_rst_n   (ext_rst_n),
        .strap_boot  (strap_boot),
        .strap_tri_n (strap_tri_n),
        .mode_o      (mode)
    );

    rstc_wdog_stretch #(.WIN(WIN)) u_wd (
        .clk       (clk_slow),
        .ext_rst_n (ext_rst_n),
        .wdog_req  (wdog_req),
        .hold_o    (wd_hold)
    );

    always_comb begin
        sys_rst_n     = pin_rel & ~wd_hold;
        boot_sel      = mode.boot;
        tsm_active    = mode.tsm;
        periph_clk_en = sys_rst_n ? periph_clk_req : '0;
        addr_out      = sys_rst_n ? addr_in : '0;
        oe_out        = mode.tsm ? '0 : oe_in;
        clk_out       = (sys_rst_n && clko_gpio_en) ? clko_gpio_val : clk_slow;
    end

    AST_ASYNC_ASSERT: assert property (@(posedge clk_slow)
        !ext_rst_n |-> !sys_rst_n); // R1
    AST_SYNC_RELEASE: assert property (@(posedge clk_slow) disable iff (!ext_rst_n)
        $rose(sys_rst_n) |-> $past(ext_rst_n)); // R2
    AST_WDOG_KEEPS_MODE: assert property (@(posedge clk_slow) disable iff (!ext_rst_n)
        (ext_rst_n && $past(ext_rst_n) && $past(ext_rst_n, 2)) |-> ($stable(boot_sel) && $stable(tsm_active))); // R8
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
    localparam int NPER = 8;
    localparam int AW   = 24;
    localparam int NOE  = 16;

    logic            clk_slow = 1'b0;
    logic            ext_rst_n = 1'b1;
    logic            wdog_req = 1'b0;
    logic            strap_boot = 1'b0;
    logic            strap_tri_n = 1'b1;
    logic [NPER-1:0] periph_clk_req = '0;
    logic [AW-1:0]   addr_in = '0;
    logic [NOE-1:0]  oe_in = '0;
    logic            clko_gpio_en = 1'b0;
    logic            clko_gpio_val = 1'b0;
    logic            sys_rst_n, boot_sel, tsm_active, clk_out;
    logic [NPER-1:0] periph_clk_en;
    logic [AW-1:0]   addr_out;
    logic [NOE-1:0]  oe_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  exp_boot = 0;
    bit  exp_tsm = 0;

    always #10 clk_slow = ~clk_slow;

    rst_seq_ctrl dut_i (
        .clk_slow(clk_slow), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
        .strap_boot(strap_boot), .strap_tri_n(strap_tri_n),
        .periph_clk_req(periph_clk_req), .addr_in(addr_in), .oe_in(oe_in),
        .clko_gpio_en(clko_gpio_en), .clko_gpio_val(clko_gpio_val),
        .sys_rst_n(sys_rst_n), .boot_sel(boot_sel), .tsm_active(tsm_active),
        .periph_clk_en(periph_clk_en), .addr_out(addr_out), .oe_out(oe_out),
        .clk_out(clk_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_tri_mode(input bit [63:0] tri_hist, input int n);
        bit all_low = 1;
        for (int k = n - 10; k < n; k++) all_low &= ~tri_hist[k];
        return all_low;
    endfunction

    // Drive random data inputs and compare gated outputs against the expected reset/mode state
    task automatic check_gates(input bit in_rst);
        periph_clk_req = NPER'($urandom);
        addr_in        = AW'($urandom);
        oe_in          = NOE'($urandom);
        clko_gpio_en   = 1'($urandom);
        clko_gpio_val  = 1'($urandom);
        #1;
        chk(periph_clk_en == (in_rst ? '0 : periph_clk_req), "R10 clk enables", periph_clk_en, in_rst ? 0 : periph_clk_req);
        chk(addr_out == (in_rst ? '0 : addr_in), "R10 address", addr_out, in_rst ? 0 : addr_in);
        chk(oe_out == (exp_tsm ? '0 : oe_in), "R6 output enables", oe_out, exp_tsm ? 0 : oe_in);
        chk(clk_out == ((!in_rst && clko_gpio_en) ? clko_gpio_val : clk_slow), "R11 clock out",
            clk_out, (!in_rst && clko_gpio_en) ? clko_gpio_val : clk_slow);
    endtask

    // tri_pat: 0 random, 1 all low, 2 all high
    task automatic ext_reset(input int n, input int tri_pat, input bit noisy_wdog);
        bit [63:0] tri_hist = '0;
        bit        last_boot = 0;
        @(posedge clk_slow); #2;
        ext_rst_n = 1'b0;
        #1;
        chk(sys_rst_n == 1'b0, "R1 async assert", sys_rst_n, 0);
        check_gates(1'b1);
        for (int k = 0; k < n; k++) begin
            strap_boot  = 1'($urandom);
            strap_tri_n = (tri_pat == 1) ? 1'b0 : (tri_pat == 2) ? 1'b1 : (($urandom % 8) == 0);
            wdog_req    = noisy_wdog ? 1'($urandom) : 1'b0;
            @(posedge clk_slow);
            tri_hist[k] = strap_tri_n;
            last_boot   = strap_boot;
            #2;
        end
        ext_rst_n   = 1'b1;
        wdog_req    = 1'b0;
        strap_boot  = 1'($urandom);
        strap_tri_n = 1'($urandom);
        if (n >= 10) begin
            exp_boot = last_boot;
            exp_tsm  = exp_tri_mode(tri_hist, n);
        end
        @(posedge clk_slow); #2;
        chk(sys_rst_n == 1'b0, "R2 still held after first edge", sys_rst_n, 0);
        chk(boot_sel == exp_boot, n >= 10 ? "R4 boot latch" : "R3 short pulse keeps boot", boot_sel, exp_boot);
        chk(tsm_active == exp_tsm, n >= 10 ? "R5 tri latch" : "R3 short pulse keeps tri", tsm_active, exp_tsm);
        @(posedge clk_slow); #2;
        chk(sys_rst_n == 1'b1, noisy_wdog ? "R9 release despite wdog" : "R2 release", sys_rst_n, 1);
        check_gates(1'b0);
    endtask

    task automatic wdog_reset();
        @(posedge clk_slow); #2;
        wdog_req = 1'b1;
        @(posedge clk_slow); #2;
        wdog_req = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk(sys_rst_n == 1'b0, "R7 wdog hold", sys_rst_n, 0);
            if (k == 3) check_gates(1'b1);
            strap_boot  = 1'($urandom);
            strap_tri_n = 1'($urandom);
            @(posedge clk_slow); #2;
        end
        chk(sys_rst_n == 1'b1, "R7 wdog release", sys_rst_n, 1);
        chk(boot_sel == exp_boot, "R8 wdog keeps boot", boot_sel, exp_boot);
        chk(tsm_active == exp_tsm, "R8 wdog keeps tri", tsm_active, exp_tsm);
        check_gates(1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        ext_reset(12, 0, 0);
        ext_reset(10, 1, 0);                 // exactly the window, tri mode on
        chk(tsm_active == 1'b1, "R5 all-low window", tsm_active, 1);
        ext_reset(9, 2, 0);                  // one short: modes stay
        chk(tsm_active == 1'b1, "R3 nine-cycle pulse", tsm_active, 1);
        wdog_reset();
        ext_reset(15, 2, 1);                 // wdog noise during pin reset
        chk(tsm_active == 1'b0, "R5 high window", tsm_active, 0);
        wdog_reset();
        for (int it = 0; it < 30; it++) begin
            if (($urandom % 3) == 0) wdog_reset();
            else ext_reset(3 + int'($urandom % 18), int'($urandom % 3), 1'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule